// File: doc/BRIEF.md
# Strided Banked Vector Load Generator

This block turns one vector load into a stream of word requests for a memory split into independent banks. A single start pulse hands it a base word address, a stride and an element count. Element number i is fetched from the base plus i times the stride, wrapping at the address width. Each request goes to the bank named by the low bits of its word address.

Every bank needs several cycles to recover after it accepts a request. The block keeps one recovery timer per bank and holds a request back while its bank is still recovering. With a unit stride, requests go out back to back. With a stride that keeps landing in the same bank, the rate drops to one element per recovery period.

Read data comes back a fixed number of cycles after each request. The block knows when each word arrives and writes it into the destination vector register with an ascending element index. After the final element has been written, it raises a one-cycle completion pulse.

Top module: `vsl_vector_ldgen`

## Requirements
- R1: The k-th request of an operation carries word address (base + k*stride) mod 2^16, and requests leave in element order.
- R2: Each request's bank output equals the low 4 bits of its word address (16 banks).
- R3: Two requests to the same bank are accepted at least 4 clock edges apart.
- R4: The first request is sampled at the first edge after the start is accepted. Each later request is sampled at the later of two edges: one edge after the previous request, and 4 edges after the last request to its own bank.
- R5: When the stride is a multiple of 16 words, every element hits one bank, and requests go out exactly one every 4 edges.
- R6: An operation issues exactly min(vlen, 64) requests and writes exactly that many elements, so a length above 64 is treated as 64.
- R7: For a request sampled at edge T, the memory data present at edge T+12 is shown on wr_data with wr_en high in the cycle after edge T+12. wr_idx counts 0, 1, 2 and so on in element order.
- R8: busy is high from the accept edge until the done pulse. done is high for exactly one cycle, the cycle after the last write. No request leaves while busy is low.
- R9: A vlen of zero issues no request and raises done in the cycle right after the accept edge.
- R10: A start pulse that arrives while busy is high has no effect on the running operation: its addresses, count and timing stay unchanged.
- R11: After reset, req_valid, wr_en, done and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while busy is low |
| base | input | 16 | Word address of element 0 |
| stride | input | 16 | Element-to-element word step, two's complement |
| vlen | input | 7 | Number of elements, clamped to 64 |
| busy | output | 1 | Operation in progress |
| req_valid | output | 1 | A memory request is issued at this edge |
| req_addr | output | 16 | Word address of the request |
| req_bank | output | 4 | Bank addressed by the request |
| rsp_data | input | 64 | Read data returned by memory at the fixed latency |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | 6 | Element index being written |
| wr_data | output | 64 | Element data being written |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each output has a fixed cycle relative to the edge that triggers it, and the bench samples at that cycle. A request that can issue appears in the same cycle that its bank timer clears, so it is sampled at the next edge. The write for that element shows up exactly 12 edges after the request. The done pulse follows one edge after the final write, or one edge after the accept edge when the length is zero. The bench keeps its own bank-recovery model, numbers the edges from a free-running counter, and compares every request edge, write edge and done edge against the expected edge number. It sweeps strides from 0 to 35 plus a set of wrapping and clamped cases.

// File: rtl/vsl_pkg.sv
package vsl_pkg;

   typedef enum logic {
      VSL_IDLE = 1'b0,
      VSL_RUN  = 1'b1
   } vsl_mode_e;

endpackage

// File: rtl/vsl_bank_timer.sv
module vsl_bank_timer #(
   parameter int NUM_BANKS = 16,
   parameter int BANK_BUSY = 4,
   parameter int BANK_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue,
   input  logic [BANK_W-1:0]    issue_bank,
   output logic [NUM_BANKS-1:0] bank_free
);

   localparam int               CNT_W  = (BANK_BUSY > 1) ? $clog2(BANK_BUSY) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BANK_BUSY - 1);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (BANK_BUSY > 1) begin : g_timed
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (issue && (issue_bank == BANK_W'(b))) begin
               cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end

         assign bank_free[b] = (cnt_q == '0);
      end else begin : g_untimed
         assign bank_free[b] = 1'b1;
      end
   end

endmodule

// File: rtl/vsl_addr_seq.sv
module vsl_addr_seq #(
   parameter int ADDR_W    = 16,
   parameter int VL_W      = 7,
   parameter int NUM_BANKS = 16,
   parameter int BANK_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ADDR_W-1:0]    base,
   input  logic [ADDR_W-1:0]    stride,
   input  logic [VL_W-1:0]      vlen,
   input  logic [NUM_BANKS-1:0] bank_free,
   output logic                 req_valid,
   output logic [ADDR_W-1:0]    req_addr,
   output logic [BANK_W-1:0]    req_bank
);

   localparam bit POW2 = ((NUM_BANKS & (NUM_BANKS - 1)) == 0);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] stride_q;
   logic [VL_W-1:0]   left_q;

   if (POW2) begin : g_pow2
      assign req_bank = addr_q[BANK_W-1:0];
   end else begin : g_mod
      assign req_bank = BANK_W'(addr_q % ADDR_W'(NUM_BANKS));
   end

   assign req_addr  = addr_q;
   assign req_valid = (left_q != '0) && bank_free[req_bank];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         stride_q <= '0;
         left_q   <= '0;
      end else if (load) begin
         addr_q   <= base;
         stride_q <= stride;
         left_q   <= vlen;
      end else if (req_valid) begin
         addr_q   <= addr_q + stride_q;
         left_q   <= left_q - VL_W'(1);
      end
   end

endmodule

// File: rtl/vsl_return_track.sv
module vsl_return_track
   import vsl_pkg::*;
#(
   parameter int MEM_LAT = 12,
   parameter int DATA_W  = 64,
   parameter int VL_W    = 7,
   parameter int IDX_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [VL_W-1:0]   vlen,
   input  logic              issue,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              done,
   output logic              busy
);

   logic [MEM_LAT-1:0] pipe_q;
   logic               tap;
   logic [VL_W-1:0]    cnt_q;
   logic [VL_W-1:0]    total_q;
   logic               last_q;
   logic               wr_en_q;
   logic [IDX_W-1:0]   wr_idx_q;
   logic [DATA_W-1:0]  wr_data_q;
   logic               done_q;
   vsl_mode_e          mode_q;

   if (MEM_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= issue;
      end
   end else begin : g_latn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[MEM_LAT-2:0], issue};
      end
   end

   assign tap = pipe_q[MEM_LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         total_q   <= '0;
         last_q    <= 1'b0;
         wr_en_q   <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
         done_q    <= 1'b0;
         mode_q    <= VSL_IDLE;
      end else begin
         wr_en_q <= tap;
         done_q  <= 1'b0;
         if (load) begin
            cnt_q   <= '0;
            total_q <= vlen;
            last_q  <= 1'b0;
            if (vlen == '0) done_q <= 1'b1;
            else            mode_q <= VSL_RUN;
         end else begin
            if (tap) begin
               wr_idx_q  <= cnt_q[IDX_W-1:0];
               wr_data_q <= rsp_data;
               last_q    <= ((cnt_q + VL_W'(1)) == total_q);
               cnt_q     <= cnt_q + VL_W'(1);
            end
            if (wr_en_q && last_q) begin
               done_q <= 1'b1;
               mode_q <= VSL_IDLE;
            end
         end
      end
   end

   assign wr_en   = wr_en_q;
   assign wr_idx  = wr_idx_q;
   assign wr_data = wr_data_q;
   assign done    = done_q;
   assign busy    = (mode_q == VSL_RUN);

endmodule

// File: rtl/vsl_vector_ldgen.sv
module vsl_vector_ldgen
   import vsl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 64,
   parameter int NUM_BANKS = 16,
   parameter int BANK_BUSY = 4,
   parameter int MEM_LAT   = 12,
   parameter int MAX_VL    = 64,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int VL_W     = $clog2(MAX_VL + 1),
   localparam int IDX_W    = $clog2(MAX_VL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [VL_W-1:0]   vlen,
   output logic              busy,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [BANK_W-1:0] req_bank,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);

   if (NUM_BANKS < 2)      begin : g_bad_banks $error("NUM_BANKS must be at least 2");      end
   if (BANK_W > ADDR_W)    begin : g_bad_addr  $error("ADDR_W too narrow for bank select"); end
   if (MAX_VL < 2)         begin : g_bad_vl    $error("MAX_VL must be at least 2");         end
   if (MEM_LAT < 1)        begin : g_bad_lat   $error("MEM_LAT must be at least 1");        end
   if (BANK_BUSY < 1)      begin : g_bad_busy  $error("BANK_BUSY must be at least 1");      end
   if (DATA_W < 1)         begin : g_bad_data  $error("DATA_W must be at least 1");         end

   localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

   logic                 accept;
   logic [VL_W-1:0]      vlen_eff;
   logic [NUM_BANKS-1:0] bank_free;

   assign accept   = start && !busy;
   assign vlen_eff = (vlen > VL_CAP) ? VL_CAP : vlen;

   vsl_bank_timer #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_BUSY (BANK_BUSY),
      .BANK_W    (BANK_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (req_valid),
      .issue_bank (req_bank),
      .bank_free  (bank_free)
   );

   vsl_addr_seq #(
      .ADDR_W    (ADDR_W),
      .VL_W      (VL_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .base      (base),
      .stride    (stride),
      .vlen      (vlen_eff),
      .bank_free (bank_free),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_bank  (req_bank)
   );

   vsl_return_track #(
      .MEM_LAT (MEM_LAT),
      .DATA_W  (DATA_W),
      .VL_W    (VL_W),
      .IDX_W   (IDX_W)
   ) u_ret (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .vlen     (vlen_eff),
      .issue    (req_valid),
      .rsp_data (rsp_data),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .done     (done),
      .busy     (busy)
   );

endmodule

// File: rtl/vsl_ldgen_chk.sv
module vsl_ldgen_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 64,
   parameter int NUM_BANKS = 16,
   parameter int BANK_BUSY = 4,
   parameter int BANK_W    = 4,
   parameter int VL_W      = 7,
   parameter int IDX_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] base,
   input logic [ADDR_W-1:0] stride,
   input logic [VL_W-1:0]   vlen,
   input logic              busy,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BANK_W-1:0] req_bank,
   input logic [DATA_W-1:0] rsp_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              done
);

   localparam int AGE_W = $clog2(BANK_BUSY + 1);

   logic              accept;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] stride_q;
   logic [ADDR_W-1:0] prev_q;
   logic              seen_q;
   logic [IDX_W-1:0]  wcnt_q;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         stride_q <= '0;
         prev_q   <= '0;
         seen_q   <= 1'b0;
         wcnt_q   <= '0;
      end else if (accept) begin
         base_q   <= base;
         stride_q <= stride;
         seen_q   <= 1'b0;
         wcnt_q   <= '0;
      end else begin
         if (req_valid) begin
            prev_q <= req_addr;
            seen_q <= 1'b1;
         end
         if (wr_en) wcnt_q <= wcnt_q + IDX_W'(1);
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
      logic [AGE_W-1:0] age_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q <= AGE_W'(BANK_BUSY);
         end else if (req_valid && (req_bank == BANK_W'(b))) begin
            age_q <= AGE_W'(1);
         end else if (age_q < AGE_W'(BANK_BUSY)) begin
            age_q <= age_q + AGE_W'(1);
         end
      end

      AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (req_bank == BANK_W'(b))) |-> (age_q >= AGE_W'(BANK_BUSY)))
         else $error("bank reused too early"); // R3
   end

   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !seen_q) |-> (req_addr == base_q))
      else $error("first address wrong"); // R1

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && seen_q) |-> (req_addr == ADDR_W'(prev_q + stride_q)))
      else $error("address step wrong"); // R1

   AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx == wcnt_q))
      else $error("write index out of order"); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle"); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid)
      else $error("request while idle"); // R8

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (vlen == '0)) |=> (done && !req_valid))
      else $error("zero length not immediate"); // R9

endmodule

bind vsl_vector_ldgen vsl_ldgen_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_BANKS (NUM_BANKS),
   .BANK_BUSY (BANK_BUSY),
   .BANK_W    (BANK_W),
   .VL_W      (VL_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .base      (base),
   .stride    (stride),
   .vlen      (vlen),
   .busy      (busy),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .req_bank  (req_bank),
   .rsp_data  (rsp_data),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .done      (done)
);

// File: tb/tb_vsl_vector_ldgen.sv
module tb_vsl_vector_ldgen;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] base = '0;
   logic [15:0] stride = '0;
   logic [6:0]  vlen = '0;
   logic        busy;
   logic        req_valid;
   logic [15:0] req_addr;
   logic [3:0]  req_bank;
   logic [63:0] rsp_data = '0;
   logic        wr_en;
   logic [5:0]  wr_idx;
   logic [63:0] wr_data;
   logic        done;

   vsl_vector_ldgen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
      .vlen(vlen), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
      .req_bank(req_bank), .rsp_data(rsp_data), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .done(done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic [63:0] memf(input logic [15:0] a);
      return {a ^ 16'hA5C3, ~a, a + 16'h1357, a};
   endfunction

   // memory model: data for a request sampled at edge T is present before edge T+12
   bit          hv[32];
   logic [15:0] ha[32];
   initial begin
      for (int i = 0; i < 32; i++) begin hv[i] = 1'b0; ha[i] = '0; end
      forever begin
         @(negedge clk);
         rsp_data = hv[(cyc - 11) & 31] ? memf(ha[(cyc - 11) & 31]) : 64'h0;
         hv[(cyc + 1) & 31] = req_valid;
         ha[(cyc + 1) & 31] = req_addr;
      end
   end

   // monitor and reference model
   bit          op_on = 1'b0;
   bit          done_seen = 1'b0;
   int          s_edge, vl_m, nreq, nwr, last_edge;
   logic [15:0] base_m, stride_m;
   int          bankfree[16];
   int          issue_edge[64];

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (req_valid) begin
               int          e;
               int          t;
               int          b;
               logic [15:0] a_exp;
               e     = cyc + 1;
               a_exp = base_m + 16'(nreq) * stride_m;
               b     = int'(a_exp[3:0]);
               chk(op_on && nreq < vl_m, "R6 request count", nreq, vl_m);
               chk(req_addr == a_exp, "R1 address", req_addr, a_exp);
               chk(req_bank == a_exp[3:0], "R2 bank", req_bank, a_exp[3:0]);
               chk(e >= bankfree[b], "R3 bank gap", e, bankfree[b]);
               t = (nreq == 0) ? s_edge + 1 : last_edge + 1;
               if (bankfree[b] > t) t = bankfree[b];
               if (stride_m[3:0] == 4'h0) chk(e == t, "R5 issue edge", e, t);
               else                        chk(e == t, "R4 issue edge", e, t);
               bankfree[b] = e + 4;
               last_edge   = e;
               if (nreq < 64) issue_edge[nreq] = e;
               nreq++;
            end
            if (wr_en) begin
               logic [63:0] d_exp;
               d_exp = memf(base_m + 16'(nwr) * stride_m);
               chk(nwr < nreq && nwr < 64, "R7 write without request", nwr, nreq);
               if (nwr < 64) chk(cyc == issue_edge[nwr] + 12, "R7 write cycle", cyc, issue_edge[nwr] + 12);
               chk(wr_idx == 6'(nwr), "R7 write index", wr_idx, nwr);
               chk(wr_data == d_exp, "R7 write data", wr_data, d_exp);
               nwr++;
            end
            if (done) begin
               int exp_c;
               exp_c = (vl_m == 0) ? s_edge : last_edge + 13;
               chk(op_on, "R8 spurious done", 1, 0);
               if (vl_m == 0) chk(cyc == exp_c, "R9 done cycle", cyc, exp_c);
               else           chk(cyc == exp_c, "R8 done cycle", cyc, exp_c);
               chk(nreq == vl_m, "R6 total requests", nreq, vl_m);
               chk(nwr == vl_m, "R6 total writes", nwr, vl_m);
               op_on     = 1'b0;
               done_seen = 1'b1;
            end else if (op_on && cyc >= s_edge) begin
               chk(busy, "R8 busy during operation", busy, 1);
            end
            if (start && !busy) begin
               op_on    = 1'b1;
               s_edge   = cyc + 1;
               base_m   = base;
               stride_m = stride;
               vl_m     = (vlen > 7'd64) ? 64 : int'(vlen);
               nreq     = 0;
               nwr      = 0;
               for (int i = 0; i < 16; i++) bankfree[i] = 0;
            end
         end
      end
   end

   task automatic run_op(input logic [15:0] b, input logic [15:0] s, input logic [6:0] n,
                         input int glitch_at);
      int waited;
      done_seen = 1'b0;
      @(posedge clk); #1;
      start = 1'b1; base = b; stride = s; vlen = n;
      @(posedge clk); #1;
      start = 1'b0; base = 16'h0; stride = 16'h0; vlen = 7'd0;
      if (glitch_at > 0) begin
         // R10: start while busy must leave the running operation untouched
         repeat (glitch_at) @(posedge clk);
         #1;
         start = 1'b1; base = 16'hDEAD; stride = 16'h0005; vlen = 7'd0;
         @(posedge clk); #1;
         start = 1'b0; base = 16'h0;
      end
      waited = 0;
      while (!done_seen && waited < 1000) begin
         @(posedge clk);
         waited++;
      end
      chk(done_seen, "R8 operation completes", done_seen, 1);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!req_valid, "R11 reset req_valid", req_valid, 0);
      chk(!wr_en, "R11 reset wr_en", wr_en, 0);
      chk(!done, "R11 reset done", done, 0);
      chk(!busy, "R11 reset busy", busy, 0);

      run_op(16'h0100, 16'h0001, 7'd64, 0);   // unit stride, full length
      run_op(16'h0007, 16'h0010, 7'd10, 0);   // R5 same bank every element
      run_op(16'h0040, 16'h0020, 7'd6, 0);    // R5 stride 32
      run_op(16'h0003, 16'h0000, 7'd5, 0);    // zero stride
      run_op(16'h0000, 16'h0008, 7'd12, 0);   // two banks alternate
      run_op(16'h0003, 16'hFFFF, 7'd17, 0);   // negative stride wraps
      run_op(16'hFFF0, 16'h0003, 7'd20, 0);   // address wrap
      run_op(16'h1234, 16'h0001, 7'd1, 0);    // single element
      run_op(16'h5555, 16'h0001, 7'd0, 0);    // R9 empty vector
      run_op(16'h0200, 16'h0001, 7'd100, 0);  // R6 clamp to 64
      run_op(16'h0300, 16'h0003, 7'd20, 5);   // R10 start while busy
      run_op(16'h0400, 16'h0010, 7'd8, 3);    // R10 during stalled issue
      for (int s = 0; s < 36; s++) begin
         run_op(16'(s * 7 + 1), 16'(s), 7'd9, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule